// File: doc/BRIEF.md
# AXI4-Stream to VGA Raster Sink

This block takes pixels from an AXI4-Stream slave port and drives a VGA display. By default the display is 640x480 with a 25 MHz pixel clock. The block runs its own horizontal and vertical counters, with an 800-clock line and a 525-line frame. From those counters it produces active-low horizontal and vertical sync pulses. It opens the stream handshake only at raster positions that need a pixel. The stream therefore paces itself to the display, and the block needs no buffer.

Alignment comes from the stream's own markers. TUSER high flags the first pixel of a frame, and TLAST high flags the last pixel of a line. After reset, or after an alignment fault, the block keeps TREADY high and drops beats until one carries TUSER. It holds that beat in a single register and shows it at the top-left pixel of the next frame. From that point it is locked. While locked, every accepted beat must carry flags that match the raster position. A mismatch raises a one-clock error pulse and sends the block back to searching. A missing beat inside the active area is shown as black and counted as an underflow.

Each 24-bit pixel is reduced to 4 bits per colour channel, using the top nibble of each byte. The colour output is forced to zero outside the visible area.

Top module: `axis_vga_sink`

## Requirements
- R1: The raster line lasts H_ACT+H_FP+H_SYNC+H_BP clocks and the frame lasts V_ACT+V_FP+V_SYNC+V_BP lines, both counted from 0 after reset. `hsync_n` is low while the column is in [H_ACT+H_FP, H_ACT+H_FP+H_SYNC). `vsync_n` is low while the line is in [V_ACT+V_FP, V_ACT+V_FP+V_SYNC). Both sync outputs, `rgb` and `align_err` reflect the raster position of the previous clock. `underflow_cnt` reflects the events of that same previous clock.
- R2: `s_tready` is combinational from internal state. While searching, it is high in every cycle. While holding the start-of-frame beat, it is low. While locked, it is high exactly when the column is below H_ACT and the line is below V_ACT.
- R3: A beat is consumed only in a cycle where `s_tvalid` and `s_tready` are both high.
- R4: While searching, beats with `s_tuser` low are discarded. The active area shows black.
- R5: The first beat accepted with `s_tuser` high is held. It is shown at column 0, line 0 of the next frame, and the block is locked from the following cycle.
- R6: A displayed pixel maps `rgb[11:8]` = `s_tdata[23:20]`, `rgb[7:4]` = `s_tdata[15:12]` and `rgb[3:0]` = `s_tdata[7:4]`.
- R7: `rgb` is zero for every raster position outside the active area.
- R8: A locked beat is faulty when its `s_tlast` differs from (column == H_ACT-1), or when its `s_tuser` differs from (column 0 and line 0). The held start-of-frame beat is faulty when its `s_tlast` differs from (H_ACT == 1). A faulty beat shows black, pulses `align_err` for one clock and returns the block to searching.
- R9: When the block is locked, the position is active and `s_tvalid` is low, the pixel is black and `underflow_cnt` increments by one. The counter wraps.
- R10: Synchronous active-high `rst` zeroes `rgb`, `align_err`, `underflow_cnt` and both counters. It drives both syncs high and enters the searching state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| s_tvalid | input | 1 | Stream beat valid |
| s_tready | output | 1 | Stream beat accepted this cycle when valid |
| s_tdata | input | 24 | Pixel, 8 bits per channel |
| s_tuser | input | 1 | Start-of-frame marker |
| s_tlast | input | 1 | End-of-line marker |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| rgb | output | 12 | Colour, 4 bits per channel |
| align_err | output | 1 | One-clock pulse on an alignment fault |
| underflow_cnt | output | UF_W | Count of missing active pixels while locked |

## Verification
`s_tready` is due in the same cycle as the raster position and lock state that produce it. The bench therefore checks it 1 ns after driving inputs on the falling edge. That is well before the next rising edge. The colour, both syncs, the error pulse and the underflow count are all due one clock after the raster cycle or beat that causes them. The bench's model computes each of these expected values when it drives the beat, and compares them on the following falling edge. The timing is shrunk by parameters to a 15x8 raster, so that many frames fit in a short run. Random gaps and corrupted markers drive the block through underflow, loss of lock and relock.

// File: rtl/vga_sink_pkg.sv
package vga_sink_pkg;

    localparam int PIX_IN_W = 24;
    localparam int RGB_W    = 12;

    typedef logic [RGB_W-1:0] rgb444_t;

    typedef enum logic [1:0] {
        LK_SEARCH = 2'd0,
        LK_ARMED  = 2'd1,
        LK_LOCKED = 2'd2
    } lock_state_e;

    // Raster position decoded for downstream stages
    typedef struct packed {
        logic active;
        logic hs_n;
        logic vs_n;
        logic at_origin;
        logic at_eol;
    } raster_pos_t;

    // Per-cycle outcome of the stream lock stage
    typedef struct packed {
        rgb444_t color;
        logic    err;
        logic    underflow;
    } pix_result_t;

    function automatic rgb444_t pack_rgb444(input logic [PIX_IN_W-1:0] d);
        return {d[23:20], d[15:12], d[7:4]};
    endfunction

endpackage

// File: rtl/vga_raster_gen.sv
module vga_raster_gen
    import vga_sink_pkg::*;
#(
    parameter int H_ACT  = 640,
    parameter int H_FP   = 16,
    parameter int H_SYNC = 96,
    parameter int H_BP   = 48,
    parameter int V_ACT  = 480,
    parameter int V_FP   = 10,
    parameter int V_SYNC = 2,
    parameter int V_BP   = 33
) (
    input  logic        clk,
    input  logic        rst,
    output raster_pos_t pos
);
    localparam int H_TOTAL = H_ACT + H_FP + H_SYNC + H_BP;
    localparam int V_TOTAL = V_ACT + V_FP + V_SYNC + V_BP;
    localparam int HW      = $clog2(H_TOTAL);
    localparam int VW      = $clog2(V_TOTAL);

    localparam logic [HW-1:0] H_LAST   = HW'(H_TOTAL - 1);
    localparam logic [VW-1:0] V_LAST   = VW'(V_TOTAL - 1);
    localparam logic [HW-1:0] H_ACT_C  = HW'(H_ACT);
    localparam logic [VW-1:0] V_ACT_C  = VW'(V_ACT);
    localparam logic [HW-1:0] H_EOL    = HW'(H_ACT - 1);
    localparam logic [HW-1:0] HS_BEG   = HW'(H_ACT + H_FP);
    localparam logic [HW-1:0] HS_END   = HW'(H_ACT + H_FP + H_SYNC);
    localparam logic [VW-1:0] VS_BEG   = VW'(V_ACT + V_FP);
    localparam logic [VW-1:0] VS_END   = VW'(V_ACT + V_FP + V_SYNC);

    logic [HW-1:0] hcnt;
    logic [VW-1:0] vcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt <= '0;
            vcnt <= '0;
        end else if (hcnt == H_LAST) begin
            hcnt <= '0;
            vcnt <= (vcnt == V_LAST) ? '0 : vcnt + 1'b1;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    always_comb begin
        pos.active    = (hcnt < H_ACT_C) && (vcnt < V_ACT_C);
        pos.hs_n      = !((hcnt >= HS_BEG) && (hcnt < HS_END));
        pos.vs_n      = !((vcnt >= VS_BEG) && (vcnt < VS_END));
        pos.at_origin = (hcnt == '0) && (vcnt == '0);
        pos.at_eol    = (hcnt == H_EOL);
    end

    AST_H_WRAP: assert property (@(posedge clk) disable iff (rst)
        (hcnt == H_LAST) |=> (hcnt == '0));                        // R1
    AST_V_HOLD: assert property (@(posedge clk) disable iff (rst)
        (hcnt != H_LAST) |=> $stable(vcnt));                        // R1

endmodule

// File: rtl/vga_stream_lock.sv
module vga_stream_lock
    import vga_sink_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                active,
    input  logic                at_origin,
    input  logic                at_eol,
    input  logic                s_tvalid,
    output logic                s_tready,
    input  logic [PIX_IN_W-1:0] s_tdata,
    input  logic                s_tuser,
    input  logic                s_tlast,
    output pix_result_t         res
);
    lock_state_e         st, st_nxt;
    logic [PIX_IN_W-1:0] hold_data;
    logic                hold_last;

    assign s_tready = (st == LK_SEARCH) || ((st == LK_LOCKED) && active);

    always_comb begin
        res    = '0;
        st_nxt = st;
        unique case (st)
            LK_SEARCH: begin
                if (s_tvalid && s_tuser) st_nxt = LK_ARMED;
            end
            LK_ARMED: begin
                if (active && at_origin) begin
                    if (hold_last != at_eol) begin
                        res.err = 1'b1;
                        st_nxt  = LK_SEARCH;
                    end else begin
                        res.color = pack_rgb444(hold_data);
                        st_nxt    = LK_LOCKED;
                    end
                end
            end
            LK_LOCKED: begin
                if (active) begin
                    if (s_tvalid) begin
                        if ((s_tlast != at_eol) || (s_tuser != at_origin)) begin
                            res.err = 1'b1;
                            st_nxt  = LK_SEARCH;
                        end else begin
                            res.color = pack_rgb444(s_tdata);
                        end
                    end else begin
                        res.underflow = 1'b1;
                    end
                end
            end
            default: st_nxt = LK_SEARCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= LK_SEARCH;
            hold_data <= '0;
            hold_last <= 1'b0;
        end else begin
            st <= st_nxt;
            if ((st == LK_SEARCH) && s_tvalid && s_tuser) begin
                hold_data <= s_tdata;
                hold_last <= s_tlast;
            end
        end
    end

    AST_SOF_ARMS: assert property (@(posedge clk) disable iff (rst)
        ((st == LK_SEARCH) && s_tvalid && s_tuser) |=> (st == LK_ARMED));          // R5
    AST_LOCK_AT_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        ((st == LK_LOCKED) && ($past(st) != LK_LOCKED))
            |-> ($past(active) && $past(at_origin)));                                // R5
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (st == LK_ARMED) |=> $stable(hold_data));                                    // R3

endmodule

// File: rtl/vga_out_stage.sv
module vga_out_stage
    import vga_sink_pkg::*;
#(
    parameter int UF_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            active,
    input  logic            hs_n,
    input  logic            vs_n,
    input  pix_result_t     res,
    output rgb444_t         rgb,
    output logic            hsync_n,
    output logic            vsync_n,
    output logic            align_err,
    output logic [UF_W-1:0] underflow_cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rgb           <= '0;
            hsync_n       <= 1'b1;
            vsync_n       <= 1'b1;
            align_err     <= 1'b0;
            underflow_cnt <= '0;
        end else begin
            rgb       <= active ? res.color : '0;
            hsync_n   <= hs_n;
            vsync_n   <= vs_n;
            align_err <= res.err;
            if (res.underflow) underflow_cnt <= underflow_cnt + 1'b1;
        end
    end

    AST_BLANK_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
        (rgb != '0) |-> $past(active));                                              // R7
    AST_UF_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((underflow_cnt == $past(underflow_cnt)) ||
                  (underflow_cnt == $past(underflow_cnt) + 1'b1)));                  // R9
    AST_ERR_BLACK: assert property (@(posedge clk) disable iff (rst)
        align_err |-> (rgb == '0));                                                  // R8

endmodule

// File: rtl/axis_vga_sink.sv
module axis_vga_sink
    import vga_sink_pkg::*;
#(
    parameter int H_ACT  = 640,
    parameter int H_FP   = 16,
    parameter int H_SYNC = 96,
    parameter int H_BP   = 48,
    parameter int V_ACT  = 480,
    parameter int V_FP   = 10,
    parameter int V_SYNC = 2,
    parameter int V_BP   = 33,
    parameter int UF_W   = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                s_tvalid,
    output logic                s_tready,
    input  logic [PIX_IN_W-1:0] s_tdata,
    input  logic                s_tuser,
    input  logic                s_tlast,
    output logic                hsync_n,
    output logic                vsync_n,
    output logic [RGB_W-1:0]    rgb,
    output logic                align_err,
    output logic [UF_W-1:0]     underflow_cnt
);
    raster_pos_t pos;
    pix_result_t res;

    vga_raster_gen #(
        .H_ACT (H_ACT),  .H_FP (H_FP),  .H_SYNC (H_SYNC),  .H_BP (H_BP),
        .V_ACT (V_ACT),  .V_FP (V_FP),  .V_SYNC (V_SYNC),  .V_BP (V_BP)
    ) u_raster (
        .clk (clk),
        .rst (rst),
        .pos (pos)
    );

    vga_stream_lock u_lock (
        .clk       (clk),
        .rst       (rst),
        .active    (pos.active),
        .at_origin (pos.at_origin),
        .at_eol    (pos.at_eol),
        .s_tvalid  (s_tvalid),
        .s_tready  (s_tready),
        .s_tdata   (s_tdata),
        .s_tuser   (s_tuser),
        .s_tlast   (s_tlast),
        .res       (res)
    );

    vga_out_stage #(.UF_W(UF_W)) u_out (
        .clk           (clk),
        .rst           (rst),
        .active        (pos.active),
        .hs_n          (pos.hs_n),
        .vs_n          (pos.vs_n),
        .res           (res),
        .rgb           (rgb),
        .hsync_n       (hsync_n),
        .vsync_n       (vsync_n),
        .align_err     (align_err),
        .underflow_cnt (underflow_cnt)
    );

endmodule

// File: tb/tb_axis_vga_sink.sv
`timescale 1ns/1ps
module tb_axis_vga_sink;
    localparam int HA = 8, HF = 2, HS = 3, HB = 2;
    localparam int VA = 4, VF = 1, VS = 1, VB = 2;
    localparam int HT = HA + HF + HS + HB;
    localparam int VT = VA + VF + VS + VB;
    localparam int UFW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic s_tvalid = 1'b0, s_tuser = 1'b0, s_tlast = 1'b0;
    logic [23:0] s_tdata = '0;
    logic s_tready, hsync_n, vsync_n, align_err;
    logic [11:0] rgb;
    logic [UFW-1:0] underflow_cnt;

    always #10 clk = ~clk;

    axis_vga_sink #(
        .H_ACT(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
        .V_ACT(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB), .UF_W(UFW)
    ) dut (
        .clk(clk), .rst(rst), .s_tvalid(s_tvalid), .s_tready(s_tready),
        .s_tdata(s_tdata), .s_tuser(s_tuser), .s_tlast(s_tlast),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .rgb(rgb),
        .align_err(align_err), .underflow_cnt(underflow_cnt)
    );

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // reference model state: 0 searching, 1 holding SOF beat, 2 locked
    int mst, mh, mv, e_uf, shown;
    logic [23:0] hd;
    logic hl;
    logic [11:0] e_rgb;
    logic e_hs, e_vs, e_err;
    string e_tag;
    // stream source position and knobs
    int sx, sy, p_valid, p_bad;
    int unused_seed = $urandom(32'h5eed_1234);

    function automatic logic [11:0] exp_color(input logic [23:0] d);
        logic [11:0] c;
        c[11:8] = d[23:20];
        c[7:4]  = d[15:12];
        c[3:0]  = d[7:4];
        return c;
    endfunction

    function automatic logic exp_sync(input int cnt, input int beg, input int len);
        return !((cnt >= beg) && (cnt < beg + len));
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        mst = 0; mh = 0; mv = 0; hd = '0; hl = 1'b0;
        e_rgb = '0; e_hs = 1'b1; e_vs = 1'b1; e_err = 1'b0; e_uf = 0;
        e_tag = "R10";
    endtask

    task automatic step();
        logic act, rdy, e_last, e_user;
        int nst;
        // registered outputs from the previous cycle
        chk({e_tag, " rgb"}, 32'(rgb), 32'(e_rgb));
        chk("R1 hsync", 32'(hsync_n), 32'(e_hs));
        chk("R1 vsync", 32'(vsync_n), 32'(e_vs));
        chk("R8 align_err", 32'(align_err), 32'(e_err));
        chk("R9 underflow_cnt", 32'(underflow_cnt), 32'(e_uf[UFW-1:0]));
        // drive a beat from the source
        s_tvalid = (($urandom % 100) < p_valid);
        s_tdata  = 24'($urandom);
        s_tuser  = (sx == 0) && (sy == 0);
        s_tlast  = (sx == HA - 1);
        if (s_tvalid && (($urandom % 100) < p_bad)) begin
            if ($urandom % 2) s_tlast = ~s_tlast;
            else              s_tuser = ~s_tuser;
        end
        #1;
        act = (mh < HA) && (mv < VA);
        rdy = (mst == 0) || ((mst == 2) && act);
        chk("R2 tready", 32'(s_tready), 32'(rdy));
        // next registered outputs
        nst = mst; e_rgb = '0; e_err = 1'b0; e_tag = act ? "R6" : "R7";
        case (mst)
            0: begin
                if (act) e_tag = "R4";
                if (s_tvalid && s_tuser) begin hd = s_tdata; hl = s_tlast; nst = 1; end
            end
            1: if (act && mh == 0 && mv == 0) begin
                e_tag = "R5";
                if (hl != (HA == 1)) begin e_err = 1'b1; nst = 0; end
                else begin e_rgb = exp_color(hd); nst = 2; shown++; end
            end
            default: if (act) begin
                if (s_tvalid) begin
                    e_last = (mh == HA - 1);
                    e_user = (mh == 0) && (mv == 0);
                    if (s_tlast != e_last || s_tuser != e_user) begin
                        e_err = 1'b1; nst = 0; e_tag = "R8";
                    end else begin
                        e_rgb = exp_color(s_tdata); shown++;
                    end
                end else begin
                    e_uf++; e_tag = "R9";
                end
            end
        endcase
        if (!act) e_rgb = '0;
        mst = nst;
        e_hs = exp_sync(mh, HA + HF, HS);
        e_vs = exp_sync(mv, VA + VF, VS);
        if (mh == HT - 1) begin mh = 0; mv = (mv == VT - 1) ? 0 : mv + 1; end
        else mh++;
        // R3: the source moves on only when the beat is handshaked
        if (s_tvalid && s_tready) begin
            sx++;
            if (sx == HA) begin sx = 0; sy = (sy == VA - 1) ? 0 : sy + 1; end
        end
    endtask

    task automatic run(input int n);
        repeat (n) begin
            step();
            @(negedge clk);
        end
    endtask

    task automatic reset_checks();
        chk("R10 rgb", 32'(rgb), 32'h0);
        chk("R10 hsync", 32'(hsync_n), 32'h1);
        chk("R10 vsync", 32'(vsync_n), 32'h1);
        chk("R10 align_err", 32'(align_err), 32'h0);
        chk("R10 underflow_cnt", 32'(underflow_cnt), 32'h0);
        chk("R10 tready", 32'(s_tready), 32'h1);
    endtask

    initial begin
        shown = 0;
        model_reset();
        repeat (3) @(negedge clk);
        reset_checks();
        rst = 1'b0;
        // R4: stream starts mid-frame, early beats must be dropped
        sx = 3; sy = 1; p_valid = 100; p_bad = 0;
        run(6 * HT * VT);
        chk("R5 pixels shown after lock", 32'(shown > 0), 32'h1);
        // R9: gaps in the stream
        p_valid = 85;
        run(6 * HT * VT);
        // R8: corrupted markers, loss of lock and relock
        p_valid = 90; p_bad = 3;
        run(20 * HT * VT);
        // R10: reset in the middle of a locked run
        p_valid = 100; p_bad = 0;
        run(3 * HT * VT + 5);
        s_tvalid = 1'b0; rst = 1'b1;
        @(negedge clk);
        reset_checks();
        rst = 1'b0;
        model_reset();
        sx = 0; sy = 0;
        shown = 0;
        run(4 * HT * VT);
        chk("R5 relock after reset", 32'(shown > 0), 32'h1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule